// File: doc/BRIEF.md
# Master Interrupt Mask and Level Mapper

The block collects thirty-two level-sensitive interrupt sources into a sticky pending register. A second register marks each source as masked or unmasked. A write port carries two command words. One command unmasks every source whose bit is set in the write data. The other command masks those sources and also discards their pending state. A fixed set of source positions is not implemented. Neither command can alter those positions, and they never become pending.

Each pending, unmasked source is translated to a processor interrupt level through a fixed table. The table does not follow bit order, and several sources share a level. The output is the highest level among the live sources, or zero when there is none. The block sits between the peripheral interrupt lines and the processor's level input.

Top module: `irq_level_master`

## Requirements
- R1: A synchronous active-high reset clears every pending bit and masks every implemented source (implemented = bits outside 0x4fb2007f). The level output is 0 after reset, even while all sources are held high.
- R2: An implemented source that is high at a clock edge sets its pending bit. The bit stays set after the source falls, until a mask command clears it.
- R3: A write to command word 2 unmasks every implemented source whose bit is 1 in the write data. Other bits are left unchanged.
- R4: A write to command word 3 masks every implemented source whose bit is 1 in the write data and clears the pending bits of those same sources.
- R5: Source positions set in 0x4fb2007f (bits 0-6, 17, 20, 21, 23-27, 30) cannot be unmasked, masked or made pending, whatever is written or driven.
- R6: Source bits map to levels as follows. Bits 0..7 map to 2,3,5,7,9,11,0,14. Bits 8..15 map to 3,5,7,9,11,13,12,12. Bits 16..23 map to 6,0,4,10,8,0,11,0. Bits 28 and 30 map to 15. Bits 24-27, 29 and 31 map to 0.
- R7: The level output equals the maximum mapped level over all bits that are pending and unmasked. It is 0 when no such bit exists. It follows the registers in the same cycle.
- R8: When a mask command and a high source hit the same bit in the same cycle, the clear wins. The bit is not pending after that edge.
- R9: Writes to command words 0 and 1 have no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Level-high interrupt sources |
| wr_en_i | input | 1 | Command write strobe |
| wr_addr_i | input | 2 | Command word select |
| wr_data_i | input | 32 | Command bit vector |
| level_o | output | 4 | Highest active processor level |

## Verification
Two functions can act on the same pending bit in one cycle: source sampling, which sets the bit, and the mask command, which clears it. The bench provokes this by raising a source only during the cycle that carries a mask write for that bit. It then drops the source and unmasks the bit. A level of 0 afterwards shows that the clear took priority. Every other cycle of the sweeps is compared against a bench model that applies the set first and the clear after it.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

    localparam int SRC_N  = 32;
    localparam int LVL_W  = 4;
    localparam int ADDR_W = 2;

    // Positions that are not implemented: never pending, never masked.
    localparam logic [SRC_N-1:0] FIXED_OFF = 32'h4fb2_007f;
    localparam logic [SRC_N-1:0] LIVE_BITS = ~FIXED_OFF;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [SRC_N-1:0] srcvec_t;

    typedef enum logic [ADDR_W-1:0] {
        CMD_IDLE0  = 2'd0,
        CMD_IDLE1  = 2'd1,
        CMD_UNMASK = 2'd2,
        CMD_MASK   = 2'd3
    } cmd_e;

    typedef struct packed {
        srcvec_t pend;
        srcvec_t dis;
    } mstate_t;

    // Source position to processor level.
    function automatic lvl_t src_level(input int unsigned idx);
        lvl_t l;
        case (idx)
            0:              l = 4'd2;
            1, 8:           l = 4'd3;
            18:             l = 4'd4;
            2, 9:           l = 4'd5;
            16:             l = 4'd6;
            3, 10:          l = 4'd7;
            20:             l = 4'd8;
            4, 11:          l = 4'd9;
            19:             l = 4'd10;
            5, 12, 22:      l = 4'd11;
            14, 15:         l = 4'd12;
            13:             l = 4'd13;
            7:              l = 4'd14;
            28, 30:         l = 4'd15;
            default:        l = 4'd0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/irqm_mask_regs.sv
module irqm_mask_regs
    import irqm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  srcvec_t             src_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  srcvec_t             wr_data_i,
    output mstate_t             state_o
);

    mstate_t st_q, st_n;
    srcvec_t wr_bits;
    srcvec_t pend_set;
    cmd_e    cmd;

    assign cmd      = cmd_e'(wr_addr_i);
    assign wr_bits  = wr_data_i & LIVE_BITS;
    assign pend_set = st_q.pend | (src_i & LIVE_BITS);

    always_comb begin
        st_n.pend = pend_set;
        st_n.dis  = st_q.dis;
        if (wr_en_i) begin
            case (cmd)
                CMD_UNMASK: st_n.dis = st_q.dis & ~wr_bits;
                CMD_MASK: begin
                    st_n.dis  = st_q.dis | wr_bits;
                    st_n.pend = pend_set & ~wr_bits;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pend <= '0;
            st_q.dis  <= LIVE_BITS;
        end else begin
            st_q <= st_n;
        end
    end

    assign state_o = st_q;

    // R3: unmask write clears the written implemented bits
    p_unmask_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == 2'd2) |=> ((st_q.dis & $past(wr_data_i) & LIVE_BITS) == '0));

    // R4: mask write masks and drops pending
    p_mask_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == 2'd3) |=>
        (((st_q.dis & $past(wr_data_i) & LIVE_BITS) == ($past(wr_data_i) & LIVE_BITS)) &&
         ((st_q.pend & $past(wr_data_i) & LIVE_BITS) == '0)));

    // R5: unimplemented positions stay zero in both registers
    p_fixed_off_r5: assert property (@(posedge clk) disable iff (rst)
        ((st_q.pend & FIXED_OFF) == '0) && ((st_q.dis & FIXED_OFF) == '0));

    // R2: pending is sticky unless a mask command is written
    p_pend_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && wr_addr_i == 2'd3) |=> ((st_q.pend & $past(st_q.pend)) == $past(st_q.pend)));

    // R9: idle command words change no mask bit
    p_idle_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_addr_i[1] == 1'b0) |=> (st_q.dis == $past(st_q.dis)));

endmodule

// File: rtl/irqm_max_fold.sv
module irqm_max_fold
    import irqm_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  lvl_t lv_i [N],
    output lvl_t max_o
);

    always_comb begin
        max_o = '0;
        for (int i = 0; i < N; i++) begin
            if (lv_i[i] > max_o) max_o = lv_i[i];
        end
    end

endmodule

// File: rtl/irqm_level_map.sv
module irqm_level_map
    import irqm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  srcvec_t active_i,
    output lvl_t    level_o
);

    lvl_t mapped [SRC_N];

    for (genvar g = 0; g < SRC_N; g++) begin : g_map
        localparam lvl_t LVL_G = src_level(g);
        assign mapped[g] = active_i[g] ? LVL_G : '0;
    end

    irqm_max_fold #(.N(SRC_N)) u_fold (
        .lv_i  (mapped),
        .max_o (level_o)
    );

    // R7: nothing active means level zero
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (active_i == '0) |-> (level_o == '0));

    // R7: a nonzero level needs an active source
    p_level_has_src_r7: assert property (@(posedge clk) disable iff (rst)
        (level_o != '0) |-> (active_i != '0));

    // R6: top level seen whenever a level-15 source is active
    p_top_level_r6: assert property (@(posedge clk) disable iff (rst)
        (active_i[28] || active_i[30]) |-> (level_o == 4'd15));

endmodule

// File: rtl/irq_level_master.sv
module irq_level_master
    import irqm_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [31:0]  src_i,
    input  logic         wr_en_i,
    input  logic [1:0]   wr_addr_i,
    input  logic [31:0]  wr_data_i,
    output logic [3:0]   level_o
);

    mstate_t st;
    srcvec_t active;

    irqm_mask_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .state_o   (st)
    );

    assign active = st.pend & ~st.dis;

    irqm_level_map u_map (
        .clk      (clk),
        .rst      (rst),
        .active_i (active),
        .level_o  (level_o)
    );

    // R1: level is zero the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (level_o == '0));

endmodule

// File: tb/tb_irq_level_master.sv
`timescale 1ns/1ps
module tb_irq_level_master;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] src;
    logic        we;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [3:0]  level;

    irq_level_master dut (
        .clk(clk), .rst(rst), .src_i(src), .wr_en_i(we),
        .wr_addr_i(addr), .wr_data_i(data), .level_o(level)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [31:0] OFFM = 32'h4fb2007f;
    localparam logic [31:0] LIVE = ~OFFM;
    int unsigned lut [32];
    logic [31:0] m_pend, m_dis;

    function automatic int unsigned exp_level();
        int unsigned best = 0;
        logic [31:0] act = m_pend & ~m_dis;
        for (int i = 0; i < 32; i++)
            if (act[i] && lut[i] > best) best = lut[i];
        return best;
    endfunction

    task automatic check(input string req, input int unsigned got, input int unsigned exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: level got %0d expected %0d", req, got, exp);
        end
    endtask

    // one clock: drive, edge, update model, sample at falling edge
    task automatic cyc(input logic [31:0] s, input logic w, input logic [1:0] a, input logic [31:0] d);
        src = s; we = w; addr = a; data = d;
        @(posedge clk);
        if (rst) begin
            m_pend = '0; m_dis = LIVE;
        end else begin
            m_pend = m_pend | (s & LIVE);
            if (w && a == 2'd2) m_dis = m_dis & ~(d & LIVE);
            if (w && a == 2'd3) begin
                m_dis  = m_dis | (d & LIVE);
                m_pend = m_pend & ~(d & LIVE);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        lut = '{2,3,5,7,9,11,0,14, 3,5,7,9,11,13,12,12,
                6,0,4,10,8,0,11,0, 0,0,0,0,15,0,15,0};
        m_pend = '0; m_dis = LIVE;
        rst = 1'b1;
        @(negedge clk);
        cyc('1, 1'b0, 2'd0, '0);
        cyc('1, 1'b1, 2'd2, '1);
        rst = 1'b0;
        check("R1 reset", level, 0);
        cyc('1, 1'b0, 2'd0, '0);
        check("R1 masked after reset", level, 0);
        check("R1 model", level, exp_level());

        // R6/R2/R4/R5 single-bit sweep
        for (int i = 0; i < 32; i++) begin
            cyc('0, 1'b1, 2'd3, '1);
            cyc('0, 1'b1, 2'd2, 32'd1 << i);
            cyc(32'd1 << i, 1'b0, 2'd0, '0);
            check(LIVE[i] ? "R6 mapping" : "R5 fixed bit", level, LIVE[i] ? lut[i] : 0);
            cyc('0, 1'b0, 2'd0, '0);
            check("R2 sticky", level, exp_level());
            cyc('0, 1'b1, 2'd3, 32'd1 << i);
            check("R4 mask clears", level, 0);
            cyc('0, 1'b1, 2'd2, 32'd1 << i);
            check("R4 pending dropped", level, 0);
        end

        // R5: everything unmasked, only fixed positions driven
        cyc('0, 1'b1, 2'd3, '1);
        cyc('0, 1'b1, 2'd2, '1);
        cyc(OFFM, 1'b0, 2'd0, '0);
        check("R5 fixed sources", level, 0);

        // R7: pseudo-random sources and masks against model
        lfsr = 32'hace1_2345;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (k % 5 == 4)
                cyc('0, 1'b1, lfsr[3] ? 2'd3 : 2'd2, lfsr & {lfsr[15:0], lfsr[31:16]});
            else
                cyc(lfsr & (lfsr >> 3) & (lfsr << 5), 1'b0, 2'd0, '0);
            check("R7 max level", level, exp_level());
        end

        // R8: mask write and source on same bit, same cycle
        cyc('0, 1'b1, 2'd3, '1);
        cyc('0, 1'b1, 2'd2, 32'h0008_0000);
        cyc(32'h0008_0000, 1'b1, 2'd3, 32'h0008_0000);
        cyc('0, 1'b1, 2'd2, 32'h0008_0000);
        check("R8 clear wins", level, 0);
        cyc(32'h0008_0000, 1'b0, 2'd0, '0);
        check("R8 later sample", level, 10);

        // R9: idle command words
        cyc('0, 1'b1, 2'd0, '1);
        cyc('0, 1'b1, 2'd1, '1);
        check("R9 idle writes", level, 10);
        cyc(32'h0000_2000, 1'b1, 2'd1, '0);
        check("R9 no unmask", level, 10);
        cyc('0, 1'b1, 2'd2, 32'h0000_2000);
        check("R7 higher wins", level, 13);
        cyc('0, 1'b1, 2'd0, 32'h0000_2000);
        check("R9 no mask", level, 13);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule